// File: doc/BRIEF.md
# Rotating Floating-Point Register Stack

This block keeps a small file of floating-point registers and presents it to an execution pipeline as a stack. The physical registers never move. A pointer, here called the top index, selects which physical register is the stack's top. Stack slot k, written ST(k), is physical register (top + k) mod NREG. A push moves the pointer down by one and fills the new top. A pop moves it up. The remaining operations copy or swap entries relative to the current top. A valid tag is kept for each physical register, so that overflow and underflow can be detected.

A request strobe arrives for each operation, and at most one operation is carried out per clock. When several strobes are raised together, a fixed priority chooses the winner. The top index, a sticky stack-fault flag and the fault's direction appear in a 16-bit status word. A combinational read port returns either a stack-relative slot or a physical register, together with its valid tag. Entry width is a parameter and defaults to 80 bits. No arithmetic is performed here.

Top module: `fp_reg_stack`

## Requirements
- R1: After reset, the top index is 0, every tag is empty, every entry reads zero and status_word is 16'h0000.
- R2: A granted push whose target ST(-1) is empty sets the top index to (top-1) mod NREG. It writes push_data into the new ST(0) and marks that register valid. Eight pushes from reset therefore wrap the index back to 0.
- R3: A granted pop with a valid ST(0) clears that tag and sets the top index to (top+1) mod NREG. A granted double pop with ST(0) and ST(1) both valid clears both tags and advances the index by 2.
- R4: A granted exchange with ST(0) and ST(st_idx) both valid swaps their contents and leaves the top index unchanged.
- R5: A granted store-pop with a valid ST(0) first copies ST(0) into ST(st_idx) and marks it valid, then pops one entry. With st_idx=0 the net effect is to discard the top, leaving that register invalid.
- R6: A granted conditional move with ST(0) and ST(st_idx) valid copies ST(st_idx) into ST(0) only when the selected condition holds; otherwise nothing changes. The condition encodings are: cond_sel 0 = CF, 1 = ZF, 2 = CF|ZF, 3 = !CF&!ZF. The top index never changes.
- R7: An operation that needs an empty register as its target but finds it occupied, or needs a valid source but finds it empty, changes nothing in the file, the tags or the top index. It sets the sticky fault bit status_word[6], and status_word[9] records the direction: 1 for a push overflow, 0 for any other fault.
- R8: status_word[13:11] carries the top index, bits 6 and 9 are as in R7, and every other bit is zero.
- R9: Only one request is served per cycle, with priority push > exchange > conditional move > store-pop > double pop > pop.
- R10: With rd_phys=0, rd_data and rd_valid show ST(rd_idx). With rd_phys=1 they show physical register rd_idx. Both follow the current state combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Push push_data |
| pop_req | input | 1 | Pop one entry |
| pop2_req | input | 1 | Pop two entries |
| xch_req | input | 1 | Swap ST(0) with ST(st_idx) |
| stpop_req | input | 1 | Copy ST(0) to ST(st_idx), then pop |
| cmov_req | input | 1 | Conditional move ST(st_idx) to ST(0) |
| push_data | input | W | Value to push |
| st_idx | input | log2(NREG) | Relative slot operand |
| cond_sel | input | 2 | Condition select for the conditional move |
| flag_cf | input | 1 | Carry-style flag |
| flag_zf | input | 1 | Zero-style flag |
| rd_phys | input | 1 | Read addressing: 1 physical, 0 relative |
| rd_idx | input | log2(NREG) | Read address |
| rd_data | output | W | Read value |
| rd_valid | output | 1 | Tag of the register read |
| status_word | output | 16 | Top index, fault flag, fault direction |

## Verification
The bench targets the following corner cases:
- **Wrap of the top index** across eight pushes. A pointer that saturates, or that fails to wrap, would leave the index away from 0.
- **Ninth push.** A design that overwrites on overflow would corrupt ST(0), and one that mislabels the fault would show the wrong direction bit.
- **Store-pop with slot 0.** This must end with an invalid register. A design that applies the copy after the pop would leave a stale valid tag.
- **Conditional move under each condition encoding**, including false conditions. A wrong decode copies when it should not.
- **Simultaneous requests**, where a lower-priority request would have succeeded but the higher-priority one faults. A wrong priority order would move the pointer.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

   localparam int NUM_REQ = 6;

   // Request bit positions, listed from lowest to highest priority.
   localparam int RQ_POP   = 0;
   localparam int RQ_POP2  = 1;
   localparam int RQ_STPOP = 2;
   localparam int RQ_CMOV  = 3;
   localparam int RQ_XCH   = 4;
   localparam int RQ_PUSH  = 5;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_POP   = 3'd1,
      OP_POP2  = 3'd2,
      OP_STPOP = 3'd3,
      OP_CMOV  = 3'd4,
      OP_XCH   = 3'd5,
      OP_PUSH  = 3'd6
   } stk_op_e;

   typedef enum logic [1:0] {
      CND_CARRY   = 2'd0,
      CND_ZERO    = 2'd1,
      CND_BELOWEQ = 2'd2,
      CND_ABOVE   = 2'd3
   } stk_cond_e;

   localparam int SW_WIDTH   = 16;
   localparam int SW_FAULT   = 6;
   localparam int SW_DIR     = 9;
   localparam int SW_TOP_LSB = 11;

endpackage

// File: rtl/fpstk_arb.sv
module fpstk_arb
   import fpstk_pkg::*;
(
   input  logic [NUM_REQ-1:0] req,
   output logic [NUM_REQ-1:0] gnt,
   output stk_op_e            op
);

   always_comb begin
      logic taken;
      taken = 1'b0;
      gnt   = '0;
      op    = OP_NONE;
      for (int k = NUM_REQ - 1; k >= 0; k--) begin
         if (req[k] && !taken) begin
            gnt[k] = 1'b1;
            op     = stk_op_e'(3'(k + 1));
            taken  = 1'b1;
         end
      end
   end

endmodule

// File: rtl/fpstk_cond.sv
module fpstk_cond
   import fpstk_pkg::*;
(
   input  stk_cond_e sel,
   input  logic      cf,
   input  logic      zf,
   output logic      ok
);

   always_comb begin
      unique case (sel)
         CND_CARRY:   ok = cf;
         CND_ZERO:    ok = zf;
         CND_BELOWEQ: ok = cf | zf;
         CND_ABOVE:   ok = ~cf & ~zf;
         default:     ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/fpstk_file.sv
module fpstk_file #(
   parameter int W    = 80,
   parameter int NREG = 8,
   localparam int PW  = $clog2(NREG)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wa_en,
   input  logic [PW-1:0]            wa_addr,
   input  logic [W-1:0]             wa_data,
   input  logic                     wb_en,
   input  logic [PW-1:0]            wb_addr,
   input  logic [W-1:0]             wb_data,
   output logic [NREG-1:0][W-1:0]   regs_o
);

   for (genvar e = 0; e < NREG; e++) begin : g_ent
      logic hit_a, hit_b;
      assign hit_a = wa_en && (wa_addr == PW'(e));
      assign hit_b = wb_en && (wb_addr == PW'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_o[e] <= '0;
         else if (hit_a)
            regs_o[e] <= wa_data;
         else if (hit_b)
            regs_o[e] <= wb_data;
      end
   end

endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
   import fpstk_pkg::*;
#(
   parameter int W    = 80,
   parameter int NREG = 8,
   localparam int PW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  stk_op_e         op,
   input  logic [PW-1:0]   idx,
   input  logic            cond_ok,
   input  logic [W-1:0]    push_data,
   input  logic [W-1:0]    st0_data,
   input  logic [W-1:0]    sti_data,
   output logic [PW-1:0]   top_o,
   output logic [PW-1:0]   ptr_sti,
   output logic [NREG-1:0] tag_o,
   output logic            fault_o,
   output logic            dir_o,
   output logic            wa_en,
   output logic [PW-1:0]   wa_addr,
   output logic [W-1:0]    wa_data,
   output logic            wb_en,
   output logic [PW-1:0]   wb_addr,
   output logic [W-1:0]    wb_data
);

   logic [PW-1:0]   top_q, top_d;
   logic [NREG-1:0] tag_q, tag_d;
   logic            flt_q, flt_d, dir_q, dir_d;
   logic [PW-1:0]   p_dn, p_up, p_up2;
   logic            v0, v1, vi, vdn, bad;

   assign p_dn    = top_q - PW'(1);
   assign p_up    = top_q + PW'(1);
   assign p_up2   = top_q + PW'(2);
   assign ptr_sti = top_q + idx;
   assign v0      = tag_q[top_q];
   assign v1      = tag_q[p_up];
   assign vi      = tag_q[ptr_sti];
   assign vdn     = tag_q[p_dn];

   always_comb begin
      top_d   = top_q;
      tag_d   = tag_q;
      flt_d   = flt_q;
      dir_d   = dir_q;
      wa_en   = 1'b0;
      wa_addr = top_q;
      wa_data = st0_data;
      wb_en   = 1'b0;
      wb_addr = ptr_sti;
      wb_data = st0_data;
      bad     = 1'b0;
      unique case (op)
         OP_PUSH: begin
            if (vdn) bad = 1'b1;
            else begin
               top_d       = p_dn;
               tag_d[p_dn] = 1'b1;
               wa_en       = 1'b1;
               wa_addr     = p_dn;
               wa_data     = push_data;
            end
         end
         OP_POP: begin
            if (!v0) bad = 1'b1;
            else begin
               tag_d[top_q] = 1'b0;
               top_d        = p_up;
            end
         end
         OP_POP2: begin
            if (!(v0 && v1)) bad = 1'b1;
            else begin
               tag_d[top_q] = 1'b0;
               tag_d[p_up]  = 1'b0;
               top_d        = p_up2;
            end
         end
         OP_STPOP: begin
            if (!v0) bad = 1'b1;
            else begin
               wa_en          = 1'b1;
               wa_addr        = ptr_sti;
               wa_data        = st0_data;
               tag_d[ptr_sti] = 1'b1;
               tag_d[top_q]   = 1'b0;
               top_d          = p_up;
            end
         end
         OP_XCH: begin
            if (!(v0 && vi)) bad = 1'b1;
            else begin
               wa_en   = 1'b1;
               wa_addr = top_q;
               wa_data = sti_data;
               wb_en   = 1'b1;
               wb_addr = ptr_sti;
               wb_data = st0_data;
            end
         end
         OP_CMOV: begin
            if (!(v0 && vi)) bad = 1'b1;
            else if (cond_ok) begin
               wa_en   = 1'b1;
               wa_addr = top_q;
               wa_data = sti_data;
            end
         end
         default: ;
      endcase
      if (bad) begin
         flt_d = 1'b1;
         dir_d = (op == OP_PUSH);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q <= '0;
         tag_q <= '0;
         flt_q <= 1'b0;
         dir_q <= 1'b0;
      end else begin
         top_q <= top_d;
         tag_q <= tag_d;
         flt_q <= flt_d;
         dir_q <= dir_d;
      end
   end

   assign top_o   = top_q;
   assign tag_o   = tag_q;
   assign fault_o = flt_q;
   assign dir_o   = dir_q;

endmodule

// File: rtl/fp_reg_stack.sv
module fp_reg_stack
   import fpstk_pkg::*;
#(
   parameter int W    = 80,
   parameter int NREG = 8,
   localparam int PW  = $clog2(NREG)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push_req,
   input  logic                 pop_req,
   input  logic                 pop2_req,
   input  logic                 xch_req,
   input  logic                 stpop_req,
   input  logic                 cmov_req,
   input  logic [W-1:0]         push_data,
   input  logic [PW-1:0]        st_idx,
   input  logic [1:0]           cond_sel,
   input  logic                 flag_cf,
   input  logic                 flag_zf,
   input  logic                 rd_phys,
   input  logic [PW-1:0]        rd_idx,
   output logic [W-1:0]         rd_data,
   output logic                 rd_valid,
   output logic [SW_WIDTH-1:0]  status_word
);

   if (NREG < 2 || (1 << PW) != NREG) begin : g_bad_nreg
      $error("fp_reg_stack: NREG must be a power of two, at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("fp_reg_stack: W must be positive");
   end
   if (SW_TOP_LSB + PW > SW_WIDTH) begin : g_bad_sw
      $error("fp_reg_stack: top field does not fit the status word");
   end

   logic [NUM_REQ-1:0]        req, gnt;
   stk_op_e                   op;
   logic                      cond_ok;
   logic [NREG-1:0][W-1:0]    regs;
   logic [PW-1:0]             top_q, ptr_sti, rd_addr;
   logic [NREG-1:0]           tag_q;
   logic                      flt, dir;
   logic                      wa_en, wb_en;
   logic [PW-1:0]             wa_addr, wb_addr;
   logic [W-1:0]              wa_data, wb_data;

   always_comb begin
      req           = '0;
      req[RQ_PUSH]  = push_req;
      req[RQ_XCH]   = xch_req;
      req[RQ_CMOV]  = cmov_req;
      req[RQ_STPOP] = stpop_req;
      req[RQ_POP2]  = pop2_req;
      req[RQ_POP]   = pop_req;
   end

   fpstk_arb u_arb (
      .req (req),
      .gnt (gnt),
      .op  (op)
   );

   fpstk_cond u_cond (
      .sel (stk_cond_e'(cond_sel)),
      .cf  (flag_cf),
      .zf  (flag_zf),
      .ok  (cond_ok)
   );

   fpstk_ctrl #(.W(W), .NREG(NREG)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .idx       (st_idx),
      .cond_ok   (cond_ok),
      .push_data (push_data),
      .st0_data  (regs[top_q]),
      .sti_data  (regs[ptr_sti]),
      .top_o     (top_q),
      .ptr_sti   (ptr_sti),
      .tag_o     (tag_q),
      .fault_o   (flt),
      .dir_o     (dir),
      .wa_en     (wa_en),
      .wa_addr   (wa_addr),
      .wa_data   (wa_data),
      .wb_en     (wb_en),
      .wb_addr   (wb_addr),
      .wb_data   (wb_data)
   );

   fpstk_file #(.W(W), .NREG(NREG)) u_file (
      .clk     (clk),
      .rst_n   (rst_n),
      .wa_en   (wa_en),
      .wa_addr (wa_addr),
      .wa_data (wa_data),
      .wb_en   (wb_en),
      .wb_addr (wb_addr),
      .wb_data (wb_data),
      .regs_o  (regs)
   );

   assign rd_addr  = rd_phys ? rd_idx : (top_q + rd_idx);
   assign rd_data  = regs[rd_addr];
   assign rd_valid = tag_q[rd_addr];

   always_comb begin
      status_word                       = '0;
      status_word[SW_TOP_LSB +: PW]     = top_q;
      status_word[SW_FAULT]             = flt;
      status_word[SW_DIR]               = dir;
   end

endmodule

// File: rtl/fpstk_chk.sv
module fpstk_chk
   import fpstk_pkg::*;
#(
   parameter int NREG = 8,
   localparam int PW  = $clog2(NREG)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                push_req,
   input logic [NUM_REQ-1:0]  gnt,
   input logic [NREG-1:0]     tag,
   input logic [SW_WIDTH-1:0] sw
);

   logic [PW-1:0] top;
   logic          flt;
   assign top = sw[SW_TOP_LSB +: PW];
   assign flt = sw[SW_FAULT];

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)); // R9

   AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      push_req |-> gnt[RQ_PUSH]); // R9

   AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[RQ_PUSH] && !tag[top - PW'(1)] |=> (top == PW'($past(top) - PW'(1))) && tag[top]); // R2

   AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[RQ_POP] && tag[top] |=> (top == PW'($past(top) + PW'(1))) && !tag[$past(top)]); // R3

   AST_XCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[RQ_XCH] |=> top == $past(top)); // R4

   AST_CMOV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[RQ_CMOV] |=> top == $past(top)); // R6

   AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[RQ_PUSH] && tag[top - PW'(1)] |=> (top == $past(top)) && flt && sw[SW_DIR]); // R7

   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flt |=> flt); // R7

endmodule

bind fp_reg_stack fpstk_chk #(.NREG(NREG)) u_fpstk_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .push_req (push_req),
   .gnt      (gnt),
   .tag      (tag_q),
   .sw       (status_word)
);

// File: tb/test_fp_reg_stack.sv
module test_fp_reg_stack;

   localparam int W = 80;
   localparam int PW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic push_req = 0, pop_req = 0, pop2_req = 0, xch_req = 0, stpop_req = 0, cmov_req = 0;
   logic [W-1:0] push_data = '0;
   logic [PW-1:0] st_idx = '0;
   logic [1:0] cond_sel = '0;
   logic flag_cf = 0, flag_zf = 0, rd_phys = 0;
   logic [PW-1:0] rd_idx = '0;
   logic [W-1:0] rd_data;
   logic rd_valid;
   logic [15:0] status_word;

   int checks = 0;
   int fails = 0;

   always #5 clk = ~clk;

   fp_reg_stack #(.W(W), .NREG(8)) i_fp_reg_stack (
      .clk(clk), .rst_n(rst_n),
      .push_req(push_req), .pop_req(pop_req), .pop2_req(pop2_req),
      .xch_req(xch_req), .stpop_req(stpop_req), .cmov_req(cmov_req),
      .push_data(push_data), .st_idx(st_idx), .cond_sel(cond_sel),
      .flag_cf(flag_cf), .flag_zf(flag_zf), .rd_phys(rd_phys), .rd_idx(rd_idx),
      .rd_data(rd_data), .rd_valid(rd_valid), .status_word(status_word)
   );

   // req bits: [5] push [4] xch [3] cmov [2] store-pop [1] double pop [0] pop
   typedef struct packed {
      logic [5:0]  req;
      logic [15:0] din;
      logic [2:0]  idx;
      logic [1:0]  cnd;
      logic        cf;
      logic        zf;
      logic [2:0]  etop;
      logic [2:0]  cidx;
      logic [15:0] eval;
      logic        evld;
      logic        eflt;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{6'b100000, 16'h0011, 3'd0, 2'd0, 1'b0, 1'b0, 3'd7, 3'd0, 16'h0011, 1'b1, 1'b0},
      '{6'b100000, 16'h0022, 3'd0, 2'd0, 1'b0, 1'b0, 3'd6, 3'd1, 16'h0011, 1'b1, 1'b0},
      '{6'b100000, 16'h0033, 3'd0, 2'd0, 1'b0, 1'b0, 3'd5, 3'd2, 16'h0011, 1'b1, 1'b0},
      '{6'b010000, 16'h0000, 3'd2, 2'd0, 1'b0, 1'b0, 3'd5, 3'd0, 16'h0011, 1'b1, 1'b0},
      '{6'b001000, 16'h0000, 3'd1, 2'd2, 1'b0, 1'b0, 3'd5, 3'd0, 16'h0011, 1'b1, 1'b0},
      '{6'b001000, 16'h0000, 3'd1, 2'd2, 1'b1, 1'b0, 3'd5, 3'd0, 16'h0022, 1'b1, 1'b0},
      '{6'b001000, 16'h0000, 3'd2, 2'd1, 1'b0, 1'b1, 3'd5, 3'd0, 16'h0033, 1'b1, 1'b0},
      '{6'b001000, 16'h0000, 3'd1, 2'd3, 1'b0, 1'b0, 3'd5, 3'd0, 16'h0022, 1'b1, 1'b0},
      '{6'b001000, 16'h0000, 3'd2, 2'd0, 1'b0, 1'b1, 3'd5, 3'd0, 16'h0022, 1'b1, 1'b0},
      '{6'b000100, 16'h0000, 3'd2, 2'd0, 1'b0, 1'b0, 3'd6, 3'd1, 16'h0022, 1'b1, 1'b0},
      '{6'b000010, 16'h0000, 3'd0, 2'd0, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000, 1'b0, 1'b0},
      '{6'b000001, 16'h0000, 3'd0, 2'd0, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000, 1'b0, 1'b1}
   };

   function automatic string tag_of(logic [5:0] r, logic f);
      if (f)        return "R7";
      if (r[5])     return "R2";
      if (r[4])     return "R4";
      if (r[3])     return "R6";
      if (r[2])     return "R5";
      return "R3";
   endfunction

   task automatic chk(string rq, string what, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic do_op(logic [5:0] r, logic [15:0] d, logic [2:0] i,
                        logic [1:0] c, logic fc, logic fz);
      @(negedge clk);
      {push_req, xch_req, cmov_req, stpop_req, pop2_req, pop_req} = r;
      push_data = W'(d);
      st_idx = i; cond_sel = c; flag_cf = fc; flag_zf = fz;
      @(negedge clk);
      {push_req, xch_req, cmov_req, stpop_req, pop2_req, pop_req} = '0;
   endtask

   task automatic rd(logic ph, logic [2:0] a);
      rd_phys = ph; rd_idx = a; #1;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(1'b0, 3'd0);
      chk("R1", "status after reset", W'(status_word), W'(16'h0000));
      chk("R1", "ST0 tag after reset", W'(rd_valid), W'(0));
      chk("R1", "ST0 data after reset", rd_data, '0);

      for (int k = 0; k < NV; k++) begin
         do_op(VEC[k].req, VEC[k].din, VEC[k].idx, VEC[k].cnd, VEC[k].cf, VEC[k].zf);
         rd(1'b0, VEC[k].cidx);
         chk(tag_of(VEC[k].req, VEC[k].eflt), $sformatf("vec%0d top", k),
             W'(status_word[13:11]), W'(VEC[k].etop));
         chk(tag_of(VEC[k].req, VEC[k].eflt), $sformatf("vec%0d data", k),
             rd_data, W'(VEC[k].eval));
         chk(tag_of(VEC[k].req, VEC[k].eflt), $sformatf("vec%0d valid", k),
             W'(rd_valid), W'(VEC[k].evld));
         chk("R7", $sformatf("vec%0d fault", k), W'(status_word[6]), W'(VEC[k].eflt));
      end
      chk("R7", "underflow direction", W'(status_word[9]), W'(0));

      // R1 second reset clears fault and tags
      do_reset();
      rd(1'b1, 3'd6);
      chk("R1", "status after re-reset", W'(status_word), W'(16'h0000));
      chk("R1", "phys6 data cleared", rd_data, '0);

      // R9 push beats pop in the same cycle
      do_op(6'b100001, 16'h0044, 3'd0, 2'd0, 0, 0);
      rd(1'b0, 3'd0);
      chk("R9", "push wins top", W'(status_word[13:11]), W'(7));
      chk("R9", "push wins data", rd_data, W'(16'h0044));
      // R9 exchange beats pop; exchange faults (ST1 empty), pop would not have
      do_op(6'b010001, 16'h0000, 3'd1, 2'd0, 0, 0);
      rd(1'b0, 3'd0);
      chk("R9", "xch over pop keeps top", W'(status_word[13:11]), W'(7));
      chk("R9", "xch over pop keeps ST0", rd_data, W'(16'h0044));
      chk("R7", "xch fault flag and dir", W'(status_word[9:6]), W'(4'b0001));

      // R2 wrap across eight pushes, R7 overflow
      do_reset();
      for (int k = 0; k < 8; k++) do_op(6'b100000, 16'(k + 1), 3'd0, 2'd0, 0, 0);
      rd(1'b0, 3'd0);
      chk("R2", "top wraps to 0", W'(status_word[13:11]), W'(0));
      chk("R2", "ST0 last pushed", rd_data, W'(16'h0008));
      rd(1'b0, 3'd7);
      chk("R2", "ST7 first pushed", rd_data, W'(16'h0001));
      rd(1'b1, 3'd7);
      chk("R10", "phys7 holds first push", rd_data, W'(16'h0001));
      chk("R10", "phys7 valid", W'(rd_valid), W'(1));
      do_op(6'b100000, 16'h0099, 3'd0, 2'd0, 0, 0);
      rd(1'b0, 3'd0);
      chk("R7", "overflow leaves ST0", rd_data, W'(16'h0008));
      chk("R7", "overflow keeps top", W'(status_word[13:11]), W'(0));
      chk("R7", "overflow fault and dir", W'({status_word[9], status_word[6]}), W'(2'b11));

      // R5 store-pop with slot 0 discards the top
      do_op(6'b000100, 16'h0000, 3'd0, 2'd0, 0, 0);
      rd(1'b0, 3'd0);
      chk("R5", "discard top index", W'(status_word[13:11]), W'(1));
      chk("R5", "new ST0", rd_data, W'(16'h0007));
      rd(1'b1, 3'd0);
      chk("R5", "discarded reg invalid", W'(rd_valid), W'(0));
      chk("R8", "full status word", W'(status_word), W'(16'h0A40));

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule